// File: doc/BRIEF.md
# SGMII Auto-Negotiation Arbiter

This block runs the link-partner handshake of a gigabit serial link. It takes the decoded receive symbol stream, one byte per accepted beat with a control-symbol flag, and picks out configuration sets and idle sets. It collects each 16-bit configuration word and steps through the arbitration phases: restart, ability detection, acknowledge detection, acknowledge completion and idle detection. When these finish it declares the link usable and reports the partner's link status, duplex and speed.

Phases that wait are timed by one of two link-timer pulses that come from outside. The PHY type selects which pulse is used. The block produces the configuration word for the transmit path to send. It does not build the outgoing ordered sets itself.

The receive side uses a valid/ready handshake. `rx_ready` is held high at all times, so the block never applies back-pressure. A beat with `rx_valid` low carries no symbol, and the set parser skips it without losing its place.

Top module: `an_sgmii_arb`

## Requirements
- R1: While `rst_n` is low: `arb_state` is 0 (disabled), `link_up`, `full_duplex` and `phy_up` are 0, `link_speed` is 2'b11 (reserved), `tx_cfg_word` is 0 and `rx_ready` is 1.
- R2: While `phy_rst_n` is low, the outputs become `arb_state` 1 (enable), `link_up`/`full_duplex`/`phy_up` 0, `link_speed` 2'b11 and `tx_cfg_word` 0. This takes priority over `neg_bypass`.
- R3: With `phy_rst_n` high and `neg_bypass` high, the next cycle shows `arb_state` 0, `phy_up` 1, `link_up` 1, `full_duplex` 1 and `link_speed` equal to `bypass_speed`.
- R4: A configuration set is comma K28.5 (0xBC, K=1), then data 0xB5 or 0x42, then the low byte and then the high byte, all with K=0. An idle set is the comma followed by data 0x50. An idle set sets `phy_up` and a received configuration word clears it. Beats with `rx_valid` low are ignored.
- R5: The link tick is `tick_short` when `phy_type`=0 and `tick_long` when `phy_type`=1. Types 2 and 3 have no tick. A timed phase ends on the second selected tick seen in that phase.
- R6: Restart (state 2) moves to ability detect (3) after its timed phase. Ability detect moves to acknowledge detect (4) on the third consecutive identical nonzero word. A different word in between starts the count again.
- R7: Acknowledge detect moves to acknowledge complete (5) only on a word that has bit 14 set and equals the captured ability in every other bit. Any other nonzero word leaves the state unchanged.
- R8: Acknowledge complete moves to idle detect (6) after a timed phase. Idle detect moves to link-ok (7) after a timed phase with no configuration word received, and any received word restarts that window.
- R9: On entry to link-ok, `link_up` takes captured bit 15, `full_duplex` takes bit 12 and `link_speed` takes bits 11:10. Outside link-ok and bypass, `link_up` is 0.
- R10: An all-zero configuration word received in states 4 to 7 returns the arbiter to restart (2) and clears `link_up`.
- R11: `tx_cfg_word` is 0 in states 0 to 2. In state 3 it is 0x0001 when `phy_type`=0 and 0x0020 otherwise. In states 4 to 7 it is that value with bit 14 set, which gives 0x4001 for SGMII.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_rst_n | input | 1 | PHY held in reset when low |
| phy_type | input | 2 | 0 SGMII, 1 fibre, 2/3 no link timer |
| tick_short | input | 1 | Short link-timer pulse |
| tick_long | input | 1 | Long link-timer pulse |
| neg_bypass | input | 1 | Skip negotiation, force link up |
| bypass_speed | input | 2 | Speed reported while bypassed |
| rx_valid | input | 1 | Receive beat valid |
| rx_ready | output | 1 | Always 1, no back-pressure |
| rx_byte | input | 8 | Decoded receive byte |
| rx_is_k | input | 1 | Byte is a control symbol |
| tx_cfg_word | output | 16 | Configuration word to transmit |
| link_up | output | 1 | Negotiated link status |
| full_duplex | output | 1 | Negotiated duplex |
| link_speed | output | 2 | Negotiated speed code |
| phy_up | output | 1 | Idle stream seen from PHY |
| arb_state | output | 3 | Arbitration state 0..7 |

## Verification
A wrong internal state shows up on `arb_state` and `tx_cfg_word` on the clock edge after the event that caused it: the acknowledge bit appears or disappears, or an advance happens too early or too late. Consistency or acknowledge faults show as the arbiter moving on at the wrong word. Timer faults show as leaving a timed phase after one tick instead of two, or leaving it on the unselected pulse. A capture fault only shows at link-ok, because that is the first time the captured word reaches `link_up`, `full_duplex` and `link_speed`.

// File: rtl/an_arb_pkg.sv
package an_arb_pkg;

  typedef enum logic [2:0] {
    ST_DISABLE      = 3'd0,
    ST_ENABLE       = 3'd1,
    ST_RESTART      = 3'd2,
    ST_ABILITY      = 3'd3,
    ST_ACK_DET      = 3'd4,
    ST_COMPLETE_ACK = 3'd5,
    ST_IDLE_DET     = 3'd6,
    ST_LINK_OK      = 3'd7
  } arb_state_e;

  typedef enum logic [1:0] {
    P_HUNT = 2'd0,
    P_TYPE = 2'd1,
    P_LO   = 2'd2,
    P_HI   = 2'd3
  } parse_state_e;

  localparam logic [7:0] SYM_COMMA = 8'hBC;
  localparam logic [7:0] SYM_CFG_A = 8'hB5;
  localparam logic [7:0] SYM_CFG_B = 8'h42;
  localparam logic [7:0] SYM_IDLE  = 8'h50;

  localparam logic [1:0] SPEED_RSVD = 2'b11;
  localparam logic [1:0] PHY_SGMII  = 2'd0;
  localparam logic [1:0] PHY_FIBRE  = 2'd1;

  localparam int ACK_BIT    = 14;
  localparam int LINK_BIT   = 15;
  localparam int DUPLEX_BIT = 12;
  localparam int SPEED_LSB  = 10;

endpackage

// File: rtl/an_link_tick.sv
module an_link_tick
  import an_arb_pkg::*;
(
  input  logic [1:0] phy_type,
  input  logic       tick_short,
  input  logic       tick_long,
  output logic       tick
);

  always_comb begin
    unique case (phy_type)
      PHY_SGMII: tick = tick_short;
      PHY_FIBRE: tick = tick_long;
      default:   tick = 1'b0;
    endcase
  end

endmodule

// File: rtl/an_os_parser.sv
module an_os_parser
  import an_arb_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CFG_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              in_is_k,
  output logic              cfg_stb,
  output logic [CFG_W-1:0]  cfg_word,
  output logic              idle_stb
);

  parse_state_e      pst;
  logic [BYTE_W-1:0] lo_q;
  logic              is_comma;

  assign is_comma = in_is_k && (in_byte == BYTE_W'(SYM_COMMA));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst      <= P_HUNT;
      lo_q     <= '0;
      cfg_stb  <= 1'b0;
      cfg_word <= '0;
      idle_stb <= 1'b0;
    end else if (!clr_n) begin
      pst      <= P_HUNT;
      lo_q     <= '0;
      cfg_stb  <= 1'b0;
      cfg_word <= '0;
      idle_stb <= 1'b0;
    end else begin
      cfg_stb  <= 1'b0;
      idle_stb <= 1'b0;
      if (in_valid) begin
        unique case (pst)
          P_HUNT: begin
            if (is_comma) pst <= P_TYPE;
          end
          P_TYPE: begin
            if (in_is_k) begin
              pst <= is_comma ? P_TYPE : P_HUNT;
            end else if (in_byte == BYTE_W'(SYM_CFG_A) ||
                         in_byte == BYTE_W'(SYM_CFG_B)) begin
              pst <= P_LO;
            end else begin
              if (in_byte == BYTE_W'(SYM_IDLE)) idle_stb <= 1'b1;
              pst <= P_HUNT;
            end
          end
          P_LO: begin
            if (in_is_k) begin
              pst <= is_comma ? P_TYPE : P_HUNT;
            end else begin
              lo_q <= in_byte;
              pst  <= P_HI;
            end
          end
          P_HI: begin
            if (in_is_k) begin
              pst <= is_comma ? P_TYPE : P_HUNT;
            end else begin
              cfg_word <= {in_byte, lo_q};
              cfg_stb  <= 1'b1;
              pst      <= P_HUNT;
            end
          end
          default: pst <= P_HUNT;
        endcase
      end
    end
  end

endmodule

// File: rtl/an_consist.sv
module an_consist #(
  parameter int W     = 16,
  parameter int DEPTH = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         cfg_stb,
  input  logic [W-1:0] cfg_word,
  output logic         match
);

  logic [W-1:0]  last_q;
  logic [CW-1:0] run_q;
  logic          same;

  assign same  = (cfg_word == last_q);
  assign match = cfg_stb && (cfg_word != '0) && same &&
                 (run_q >= CW'(DEPTH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      run_q  <= '0;
    end else if (!clr_n) begin
      last_q <= '0;
      run_q  <= '0;
    end else if (cfg_stb) begin
      last_q <= cfg_word;
      if (!same)                     run_q <= CW'(1);
      else if (run_q != CW'(DEPTH))  run_q <= run_q + CW'(1);
    end
  end

endmodule

// File: rtl/an_arb_fsm.sv
module an_arb_fsm
  import an_arb_pkg::*;
#(
  parameter int          W         = 16,
  parameter logic [15:0] SGMII_ADV = 16'h0001,
  parameter logic [15:0] FIBRE_ADV = 16'h0020
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phy_rst_n,
  input  logic         bypass,
  input  logic [1:0]   bypass_speed,
  input  logic [1:0]   phy_type,
  input  logic         tick,
  input  logic         cfg_stb,
  input  logic [W-1:0] cfg_word,
  input  logic         idle_stb,
  input  logic         ability_match,
  output logic [W-1:0] tx_cfg_word,
  output logic         link_up,
  output logic         full_duplex,
  output logic [1:0]   link_speed,
  output logic         phy_up,
  output logic [2:0]   state_out
);

  localparam logic [W-1:0] ACK_MASK = W'(1) << ACK_BIT;

  arb_state_e   state, nxt;
  logic         armed;
  logic [W-1:0] ability;
  logic         timed, period_done, zero_cfg, ack_ok;
  logic [W-1:0] base_adv, tx_nxt;

  assign timed       = (state == ST_RESTART) || (state == ST_COMPLETE_ACK) ||
                       (state == ST_IDLE_DET);
  assign period_done = timed && tick && armed;
  assign zero_cfg    = cfg_stb && (cfg_word == '0);
  assign ack_ok      = cfg_stb && cfg_word[ACK_BIT] &&
                       ((cfg_word | ACK_MASK) == (ability | ACK_MASK));
  assign base_adv    = (phy_type == PHY_SGMII) ? W'(SGMII_ADV) : W'(FIBRE_ADV);

  always_comb begin
    nxt = state;
    if (!phy_rst_n) begin
      nxt = ST_ENABLE;
    end else if (bypass) begin
      nxt = ST_DISABLE;
    end else begin
      unique case (state)
        ST_DISABLE:  nxt = ST_ENABLE;
        ST_ENABLE:   nxt = ST_RESTART;
        ST_RESTART:  if (period_done) nxt = ST_ABILITY;
        ST_ABILITY:  if (ability_match) nxt = ST_ACK_DET;
        ST_ACK_DET: begin
          if (zero_cfg)    nxt = ST_RESTART;
          else if (ack_ok) nxt = ST_COMPLETE_ACK;
        end
        ST_COMPLETE_ACK: begin
          if (zero_cfg)         nxt = ST_RESTART;
          else if (period_done) nxt = ST_IDLE_DET;
        end
        ST_IDLE_DET: begin
          if (zero_cfg)                       nxt = ST_RESTART;
          else if (period_done && !cfg_stb)   nxt = ST_LINK_OK;
        end
        ST_LINK_OK:  if (zero_cfg) nxt = ST_RESTART;
        default:     nxt = ST_DISABLE;
      endcase
    end
  end

  always_comb begin
    unique case (nxt)
      ST_DISABLE, ST_ENABLE, ST_RESTART: tx_nxt = '0;
      ST_ABILITY:                        tx_nxt = base_adv;
      default:                           tx_nxt = base_adv | ACK_MASK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_DISABLE;
      armed   <= 1'b0;
      ability <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)                          armed <= 1'b0;
      else if (state == ST_IDLE_DET && cfg_stb)  armed <= 1'b0;
      else if (timed && tick)                    armed <= 1'b1;
      if (state == ST_ABILITY && ability_match)  ability <= cfg_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cfg_word <= '0;
      link_up     <= 1'b0;
      full_duplex <= 1'b0;
      link_speed  <= SPEED_RSVD;
      phy_up      <= 1'b0;
    end else begin
      tx_cfg_word <= tx_nxt;
      if (!phy_rst_n) begin
        link_up     <= 1'b0;
        full_duplex <= 1'b0;
        link_speed  <= SPEED_RSVD;
        phy_up      <= 1'b0;
      end else if (bypass) begin
        link_up     <= 1'b1;
        full_duplex <= 1'b1;
        link_speed  <= bypass_speed;
        phy_up      <= 1'b1;
      end else begin
        if (nxt == ST_LINK_OK && state != ST_LINK_OK) begin
          link_up     <= ability[LINK_BIT];
          full_duplex <= ability[DUPLEX_BIT];
          link_speed  <= ability[SPEED_LSB +: 2];
        end else if (nxt != ST_LINK_OK) begin
          link_up     <= 1'b0;
          full_duplex <= 1'b0;
          link_speed  <= SPEED_RSVD;
        end
        if (idle_stb)     phy_up <= 1'b1;
        else if (cfg_stb) phy_up <= 1'b0;
      end
    end
  end

  assign state_out = state;

endmodule

// File: rtl/an_sgmii_arb.sv
module an_sgmii_arb
  import an_arb_pkg::*;
#(
  parameter int          BYTE_W    = 8,
  parameter int          CONSIST_N = 3,
  parameter logic [15:0] SGMII_ADV = 16'h0001,
  parameter logic [15:0] FIBRE_ADV = 16'h0020,
  localparam int         CFG_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phy_rst_n,
  input  logic [1:0]        phy_type,
  input  logic              tick_short,
  input  logic              tick_long,
  input  logic              neg_bypass,
  input  logic [1:0]        bypass_speed,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_is_k,
  output logic [CFG_W-1:0]  tx_cfg_word,
  output logic              link_up,
  output logic              full_duplex,
  output logic [1:0]        link_speed,
  output logic              phy_up,
  output logic [2:0]        arb_state
);

  logic             tick;
  logic             cfg_stb, idle_stb, ability_match;
  logic [CFG_W-1:0] cfg_word;

  assign rx_ready = 1'b1;

  an_link_tick u_tick (
    .phy_type   (phy_type),
    .tick_short (tick_short),
    .tick_long  (tick_long),
    .tick       (tick)
  );

  an_os_parser #(.BYTE_W(BYTE_W)) u_parse (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (phy_rst_n),
    .in_valid (rx_valid),
    .in_byte  (rx_byte),
    .in_is_k  (rx_is_k),
    .cfg_stb  (cfg_stb),
    .cfg_word (cfg_word),
    .idle_stb (idle_stb)
  );

  an_consist #(.W(CFG_W), .DEPTH(CONSIST_N)) u_consist (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (phy_rst_n),
    .cfg_stb  (cfg_stb),
    .cfg_word (cfg_word),
    .match    (ability_match)
  );

  an_arb_fsm #(.W(CFG_W), .SGMII_ADV(SGMII_ADV), .FIBRE_ADV(FIBRE_ADV)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .phy_rst_n     (phy_rst_n),
    .bypass        (neg_bypass),
    .bypass_speed  (bypass_speed),
    .phy_type      (phy_type),
    .tick          (tick),
    .cfg_stb       (cfg_stb),
    .cfg_word      (cfg_word),
    .idle_stb      (idle_stb),
    .ability_match (ability_match),
    .tx_cfg_word   (tx_cfg_word),
    .link_up       (link_up),
    .full_duplex   (full_duplex),
    .link_speed    (link_speed),
    .phy_up        (phy_up),
    .state_out     (arb_state)
  );

endmodule

// File: rtl/an_sgmii_arb_chk.sv
module an_sgmii_arb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        phy_rst_n,
  input logic        neg_bypass,
  input logic [15:0] tx_cfg_word,
  input logic        link_up,
  input logic        phy_up,
  input logic [1:0]  link_speed,
  input logic [2:0]  arb_state
);

  AST_PHY_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_rst_n |=> (!link_up && !phy_up && link_speed == 2'b11 && arb_state == 3'd1)); // R2

  AST_BYPASS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_rst_n && neg_bypass) |=> (phy_up && link_up && arb_state == 3'd0)); // R3

  AST_RESTART_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_state == 3'd2) |-> (tx_cfg_word == 16'h0000)); // R11

  AST_ACK_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_state >= 3'd4) |-> tx_cfg_word[14]); // R11

  AST_LINK_ONLY_OK: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (arb_state == 3'd7 || arb_state == 3'd0)); // R9

  AST_COMPLETE_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_state == 3'd5 && $past(arb_state) != 3'd5) |-> ($past(arb_state) == 3'd4)); // R7

  AST_LINK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_state == 3'd7 && $past(arb_state) != 3'd7) |-> ($past(arb_state) == 3'd6)); // R8

endmodule

bind an_sgmii_arb an_sgmii_arb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .phy_rst_n   (phy_rst_n),
  .neg_bypass  (neg_bypass),
  .tx_cfg_word (tx_cfg_word),
  .link_up     (link_up),
  .phy_up      (phy_up),
  .link_speed  (link_speed),
  .arb_state   (arb_state)
);

// File: tb/an_sgmii_arb_bench.sv
module an_sgmii_arb_bench;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phy_rst_n = 1'b1;
  logic [1:0]  phy_type = 2'd0;
  logic        tick_short = 1'b0;
  logic        tick_long = 1'b0;
  logic        neg_bypass = 1'b0;
  logic [1:0]  bypass_speed = 2'd0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_byte = 8'h00;
  logic        rx_is_k = 1'b0;
  logic [15:0] tx_cfg_word;
  logic        link_up, full_duplex, phy_up;
  logic [1:0]  link_speed;
  logic [2:0]  arb_state;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  an_sgmii_arb u_an_sgmii_arb (
    .clk (clk), .rst_n (rst_n), .phy_rst_n (phy_rst_n), .phy_type (phy_type),
    .tick_short (tick_short), .tick_long (tick_long), .neg_bypass (neg_bypass),
    .bypass_speed (bypass_speed), .rx_valid (rx_valid), .rx_ready (rx_ready),
    .rx_byte (rx_byte), .rx_is_k (rx_is_k), .tx_cfg_word (tx_cfg_word),
    .link_up (link_up), .full_duplex (full_duplex), .link_speed (link_speed),
    .phy_up (phy_up), .arb_state (arb_state)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b0;
    end
  endtask

  task automatic put_byte(input logic k, input logic [7:0] b, input bit gap);
    if (gap) begin
      @(negedge clk);
      rx_valid = 1'b0; rx_is_k = 1'b1; rx_byte = 8'hBC;
    end
    @(negedge clk);
    rx_valid = 1'b1; rx_is_k = k; rx_byte = b;
  endtask

  task automatic send_cfg(input logic [15:0] w, input bit second, input bit gap);
    put_byte(1'b1, 8'hBC, gap);
    put_byte(1'b0, second ? 8'h42 : 8'hB5, gap);
    put_byte(1'b0, w[7:0], gap);
    put_byte(1'b0, w[15:8], gap);
    settle(3);
  endtask

  task automatic send_idle();
    put_byte(1'b1, 8'hBC, 1'b0);
    put_byte(1'b0, 8'h50, 1'b0);
    settle(3);
  endtask

  task automatic pulse(input bit long_one);
    @(negedge clk);
    tick_short = !long_one; tick_long = long_one;
    @(negedge clk);
    tick_short = 1'b0; tick_long = 1'b0;
    settle(2);
  endtask

  task automatic do_reset(input logic [1:0] pt);
    rst_n = 1'b0; phy_type = pt;
    settle(3);
    rst_n = 1'b1;
    settle(4);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R1 reset state
    settle(3);
    chk("R1 state", arb_state, 0);
    chk("R1 link_up", link_up, 0);
    chk("R1 duplex", full_duplex, 0);
    chk("R1 speed", link_speed, 3);
    chk("R1 phy_up", phy_up, 0);
    chk("R1 tx", tx_cfg_word, 0);
    chk("R1 ready", rx_ready, 1);
    rst_n = 1'b1;
    settle(4);
    chk("R11 restart tx", tx_cfg_word, 0);
    chk("R6 in restart", arb_state, 2);

    // R5 timer selection sweep
    for (int pt = 0; pt < 4; pt++) begin
      do_reset(2'(pt));
      pulse(1'b0);
      chk("R5 one tick", arb_state, 2);
      pulse(1'b0);
      chk("R5 short pair", arb_state, (pt == 0) ? 3 : 2);
      pulse(1'b1);
      pulse(1'b1);
      chk("R5 long pair", arb_state, (pt <= 1) ? 3 : 2);
      if (pt <= 1) chk("R11 ability tx", tx_cfg_word, (pt == 0) ? 16'h0001 : 16'h0020);
    end

    // Negotiation sweep over link/duplex/speed abilities
    do_reset(2'd0);
    pulse(1'b0); pulse(1'b0);
    for (int i = 0; i < 16; i++) begin
      logic [15:0] ab;
      ab = 16'(((i >> 3) & 1) << 15) | 16'(((i >> 2) & 1) << 12) |
           16'((i & 3) << 10) | 16'h0001;
      chk("R6 ability entry", arb_state, 3);
      if (i == 0) begin
        send_cfg(ab, 1'b0, 1'b0);
        send_cfg(ab, 1'b1, 1'b0);
        send_cfg(ab ^ 16'h0100, 1'b0, 1'b0);
        send_cfg(ab, 1'b1, 1'b0);
        send_cfg(ab, 1'b0, 1'b0);
        chk("R6 broken run", arb_state, 3);
        send_cfg(ab, 1'b1, 1'b0);
      end else begin
        for (int j = 0; j < 3; j++) send_cfg(ab, j[0], i == 1);
        if (i == 1) chk("R4 gaps ignored", arb_state, 4);
      end
      chk("R6 ack detect", arb_state, 4);
      chk("R11 ack tx", tx_cfg_word, 16'h4001);
      if (i == 0) begin
        send_cfg((ab ^ 16'h0100) | 16'h4000, 1'b0, 1'b0);
        chk("R7 mismatch", arb_state, 4);
        send_cfg(ab, 1'b1, 1'b0);
        chk("R7 no ack bit", arb_state, 4);
      end
      send_cfg(ab | 16'h4000, 1'b0, 1'b0);
      chk("R7 complete", arb_state, 5);
      pulse(1'b0);
      chk("R8 complete hold", arb_state, 5);
      pulse(1'b0);
      chk("R8 idle detect", arb_state, 6);
      if (i == 0) begin
        pulse(1'b0);
        send_cfg(ab | 16'h4000, 1'b1, 1'b0);
        chk("R4 cfg clears phy_up", phy_up, 0);
        pulse(1'b0);
        chk("R8 window restart", arb_state, 6);
      end
      send_idle();
      chk("R4 idle phy_up", phy_up, 1);
      pulse(1'b0);
      pulse(1'b0);
      chk("R8 link ok", arb_state, 7);
      chk("R9 link_up", link_up, (i >> 3) & 1);
      chk("R9 duplex", full_duplex, (i >> 2) & 1);
      chk("R9 speed", link_speed, i & 3);
      send_cfg(16'h0000, 1'b1, 1'b0);
      chk("R10 restart", arb_state, 2);
      chk("R10 link down", link_up, 0);
      pulse(1'b0); pulse(1'b0);
    end

    // R3 bypass sweep, then R2 priority
    for (int s = 0; s < 4; s++) begin
      bypass_speed = 2'(s);
      neg_bypass = 1'b1;
      settle(3);
      chk("R3 state", arb_state, 0);
      chk("R3 link", link_up, 1);
      chk("R3 duplex", full_duplex, 1);
      chk("R3 speed", link_speed, s);
      chk("R3 phy_up", phy_up, 1);
    end
    phy_rst_n = 1'b0;
    settle(3);
    chk("R2 state", arb_state, 1);
    chk("R2 link", link_up, 0);
    chk("R2 duplex", full_duplex, 0);
    chk("R2 speed", link_speed, 3);
    chk("R2 phy_up", phy_up, 0);
    chk("R2 tx", tx_cfg_word, 0);
    phy_rst_n = 1'b1;
    neg_bypass = 1'b0;
    settle(4);
    chk("R6 back to restart", arb_state, 2);

    summary();
  end

endmodule